// File: doc/BRIEF.md
# Grouped Channel Event Interrupt Controller

This block gathers single-cycle event pulses raised by ten data channels, each channel able to report six kinds of event, and keeps every one of them in a sticky status bit until software clears it. A per-bit enable selects which captured events may interrupt. A masked view shows which captured events are also enabled. A second mask, one bit per channel, decides which channels may drive the single combined interrupt line.

Software reaches the state through a flat word-addressed port with an address, a write strobe, write data and combinational read data. Channels are packed four to a 32-bit word, one byte lane each. The event code selects the bit inside the lane. Channels 8 and 9 use the two low lanes of a third word. A service routine reads the masked words, clears the events it has handled with write-one-to-clear writes, and keeps scanning every channel.

Top module: `chan_event_irq`

## Requirements
- R1: After reset every enable, status and host-mask bit is zero, every address reads zero and `irq_o` is low.
- R2: Channel c, event e sits in word group c/4 at bit 8*(c mod 4)+e. Channels 8 and 9 therefore use bits 0..5 and 8..13 of group 2. Enable words are at addresses 0..2.
- R3: An event input bit `evt_i[6*c+e]` high at a clock edge sets its status bit, which is readable at addresses 6..8 from the next cycle and stays set until cleared.
- R4: A write to addresses 3..5 clears each status bit of that group whose write-data bit is 1. Bits written 0 keep their value, and the clear addresses read zero.
- R5: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Addresses 9..11 read status AND enable for their group.
- R7: Address 12 holds the host mask. Bit n gates channel n, and bits 10..31 read zero.
- R8: `irq_o` is high exactly when some channel has its host-mask bit set and at least one of its status bits set with the matching enable bit set. It follows the register state with no added delay.
- R9: Lane bits 6 and 7, lanes 2 and 3 of group 2, and addresses 13..15 read zero, and writes to them have no effect.
- R10: Status bits capture events while their enable bit is zero, so enabling later makes the pending event visible in the masked view and on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 60 | Event pulses, bit 6*channel+code |
| reg_addr | input | 4 | Word address for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a clear write landing on a status bit in the same cycle as a new pulse for that bit. Random stimulus seldom lines these up, so a directed step drives a pulse for channel 5 event 1 together with a clear of exactly that bit, then reads the raw word. Long random phases mix sparse pulses with writes to every address, including the unmapped ones, and a behavioural model checks read data and the interrupt on every cycle. Those phases also cover the third, half-filled group and its unused lanes.

// File: rtl/icg_pkg.sv
package icg_pkg;
  localparam int LANE_W    = 8;
  localparam int LANES     = 4;
  localparam int DATA_W    = LANE_W * LANES;

  typedef enum logic [2:0] {
    RG_EN   = 3'd0,
    RG_CLR  = 3'd1,
    RG_RAW  = 3'd2,
    RG_MSK  = 3'd3,
    RG_HOST = 3'd4,
    RG_NONE = 3'd5
  } reg_kind_e;
endpackage

// File: rtl/icg_addr_dec.sv
module icg_addr_dec
  import icg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NGRP   = 3,
  parameter int GRP_W  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [GRP_W-1:0]  grp_o
);
  localparam int HOST_ADDR = 4 * NGRP;

  always_comb begin
    kind_o = RG_NONE;
    grp_o  = '0;
    if (int'(addr_i) == HOST_ADDR) begin
      kind_o = RG_HOST;
    end else if (int'(addr_i) < HOST_ADDR) begin
      grp_o = GRP_W'(int'(addr_i) % NGRP);
      case (int'(addr_i) / NGRP)
        0:       kind_o = RG_EN;
        1:       kind_o = RG_CLR;
        2:       kind_o = RG_RAW;
        default: kind_o = RG_MSK;
      endcase
    end
  end
endmodule

// File: rtl/icg_chan_cell.sv
module icg_chan_cell #(
  parameter int NEV = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt_i,
  input  logic           en_we_i,
  input  logic           clr_we_i,
  input  logic [NEV-1:0] wdata_i,
  output logic [NEV-1:0] raw_o,
  output logic [NEV-1:0] en_o,
  output logic           pend_o
);
  logic [NEV-1:0] raw_q, raw_d, en_q, en_d, clr_mask;

  always_comb begin
    clr_mask = clr_we_i ? wdata_i : '0;
    raw_d    = evt_i | (raw_q & ~clr_mask);
    en_d     = en_we_i ? wdata_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      raw_q <= raw_d;
      if (en_we_i) en_q <= en_d;
    end
  end

  assign raw_o  = raw_q;
  assign en_o   = en_q;
  assign pend_o = |(raw_q & en_q);

  // R3
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((raw_o & $past(evt_i)) == $past(evt_i)));
  // R3
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we_i |=> ((raw_o & $past(raw_o)) == $past(raw_o)));
  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((raw_o & $past(wdata_i & ~evt_i)) == '0));
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && |(evt_i & wdata_i)) |=>
      ((raw_o & $past(evt_i & wdata_i)) == $past(evt_i & wdata_i)));
  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we_i |=> $stable(en_o));
endmodule

// File: rtl/chan_event_irq.sv
module chan_event_irq
  import icg_pkg::*;
#(
  parameter int NCH    = 10,
  parameter int NEV    = 6,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*NEV-1:0] evt_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam int NGRP  = (NCH + LANES - 1) / LANES;
  localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1;

  reg_kind_e        kind;
  logic [GRP_W-1:0] grp;
  logic [NEV-1:0]   raw_all [NCH];
  logic [NEV-1:0]   en_all  [NCH];
  logic [NCH-1:0]   pend;
  logic [NCH-1:0]   hm_q, hm_d;
  logic             hm_we;

  icg_addr_dec #(.ADDR_W(ADDR_W), .NGRP(NGRP), .GRP_W(GRP_W)) u_dec (
    .addr_i (reg_addr),
    .kind_o (kind),
    .grp_o  (grp)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int G = ch / LANES;
    localparam int L = ch % LANES;
    logic en_we, clr_we;
    assign en_we  = reg_wr && (kind == RG_EN)  && (grp == GRP_W'(G));
    assign clr_we = reg_wr && (kind == RG_CLR) && (grp == GRP_W'(G));

    icg_chan_cell #(.NEV(NEV)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i[ch*NEV +: NEV]),
      .en_we_i  (en_we),
      .clr_we_i (clr_we),
      .wdata_i  (reg_wdata[L*LANE_W +: NEV]),
      .raw_o    (raw_all[ch]),
      .en_o     (en_all[ch]),
      .pend_o   (pend[ch])
    );
  end

  always_comb begin
    hm_we = reg_wr && (kind == RG_HOST);
    hm_d  = hm_we ? reg_wdata[NCH-1:0] : hm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hm_q <= '0;
    else if (hm_we) hm_q <= hm_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (kind == RG_HOST) begin
      reg_rdata[NCH-1:0] = hm_q;
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (ch / LANES == int'(grp)) begin
          case (kind)
            RG_EN:   reg_rdata[(ch % LANES)*LANE_W +: NEV] = en_all[ch];
            RG_RAW:  reg_rdata[(ch % LANES)*LANE_W +: NEV] = raw_all[ch];
            RG_MSK:  reg_rdata[(ch % LANES)*LANE_W +: NEV] = raw_all[ch] & en_all[ch];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    irq_o = 1'b0;
    for (int ch = 0; ch < NCH; ch++) irq_o = irq_o | (hm_q[ch] & pend[ch]);
  end

  // R8
  host_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hm_q == '0) |-> !irq_o);
  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == RG_NONE) |-> (reg_rdata == '0));
  // R4
  clr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == RG_CLR) |-> (reg_rdata == '0));
endmodule

// File: tb/tb_chan_event_irq.sv
module tb_chan_event_irq;
  localparam int NCH = 10;
  localparam int NEV = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH*NEV-1:0] evt_i;
  logic [3:0]        reg_addr;
  logic              reg_wr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic              irq_o;

  int nchk = 0;
  int nerr = 0;

  bit       rawm [NCH][NEV];
  bit       enm  [NCH][NEV];
  bit [9:0] hmm;

  chan_event_irq dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (rawm[c, e]) begin rawm[c][e] = 0; enm[c][e] = 0; end
      hmm = '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        for (int e = 0; e < NEV; e++) begin
          int b;
          bit clr;
          b   = (c % 4) * 8 + e;
          clr = reg_wr && (int'(reg_addr) == 3 + c / 4) && reg_wdata[b];
          rawm[c][e] = evt_i[c*NEV+e] || (rawm[c][e] && !clr);
          if (reg_wr && int'(reg_addr) == c / 4) enm[c][e] = reg_wdata[b];
        end
      end
      if (reg_wr && reg_addr == 4'd12) hmm = reg_wdata[9:0];
    end
  end

  function automatic logic [31:0] exp_rd(int a);
    logic [31:0] r = '0;
    if (a == 12) return {22'd0, hmm};
    for (int c = 0; c < NCH; c++) begin
      for (int e = 0; e < NEV; e++) begin
        int b = (c % 4) * 8 + e;
        if (a == c / 4) r[b] = enm[c][e];
        else if (a == 6 + c / 4) r[b] = rawm[c][e];
        else if (a == 9 + c / 4) r[b] = rawm[c][e] & enm[c][e];
      end
    end
    return r;
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int c = 0; c < NCH; c++)
      for (int e = 0; e < NEV; e++)
        if (hmm[c] && rawm[c][e] && enm[c][e]) r = 1'b1;
    return r;
  endfunction

  function automatic string tag_of(int a);
    if (a < 3) return "R2";
    if (a < 6) return "R4";
    if (a < 9) return "R3";
    if (a < 12) return "R6";
    if (a == 12) return "R7";
    return "R9";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(logic [NCH*NEV-1:0] ev, logic wr, logic [3:0] a, logic [31:0] wd);
    @(negedge clk);
    chk(tag_of(int'(reg_addr)), reg_rdata, exp_rd(int'(reg_addr)));
    chk("R8", {31'd0, irq_o}, {31'd0, exp_irq()});
    evt_i = ev; reg_wr = wr; reg_addr = a; reg_wdata = wd;
  endtask

  task automatic peek(logic [3:0] a, string tag, logic [31:0] exp);
    @(negedge clk);
    evt_i = '0; reg_wr = 1'b0; reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #1000000;
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; evt_i = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    #12;
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 16; a++) peek(4'(a), "R1", 32'h0);
    chk("R1", {31'd0, irq_o}, 32'h0);
    // R2 R3 channel 9 event 3 -> group 2 bit 11
    cyc(60'd1 << 57, 1'b0, 4'd8, 32'h0);
    peek(4'd8, "R3", 32'h0000_0800);
    peek(4'd2, "R2", 32'h0);
    peek(4'd11, "R10", 32'h0);
    cyc('0, 1'b1, 4'd2, 32'h0000_0800);
    peek(4'd11, "R10", 32'h0000_0800);
    chk("R7", {31'd0, irq_o}, 32'h0);
    cyc('0, 1'b1, 4'd12, 32'hFFFF_FFFF);
    peek(4'd12, "R7", 32'h0000_03FF);
    chk("R8", {31'd0, irq_o}, 32'h1);
    // R5 channel 5 event 1 (group 1 bit 9): pulse and clear together
    cyc(60'd1 << 31, 1'b1, 4'd4, 32'h0000_0200);
    peek(4'd7, "R5", 32'h0000_0200);
    cyc('0, 1'b1, 4'd4, 32'h0000_0200);
    peek(4'd7, "R4", 32'h0);
    cyc('0, 1'b1, 4'd5, 32'h0);
    peek(4'd8, "R4", 32'h0000_0800);
    peek(4'd5, "R4", 32'h0);
    // R9 unused lanes and bits
    cyc('0, 1'b1, 4'd2, 32'hFFFF_FFFF);
    peek(4'd2, "R9", 32'h0000_3F3F);
    cyc('0, 1'b1, 4'd13, 32'hFFFF_FFFF);
    peek(4'd13, "R9", 32'h0);
    peek(4'd2, "R9", 32'h0000_3F3F);
    cyc('0, 1'b1, 4'd5, 32'h0000_0800);
    peek(4'd8, "R4", 32'h0);
    chk("R8", {31'd0, irq_o}, 32'h0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [NCH*NEV-1:0] ev = '0;
      logic [31:0] wd;
      for (int b = 0; b < NCH*NEV; b++) ev[b] = ($urandom_range(0, 15) == 0);
      wd = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : 32'($urandom());
      cyc(ev, ($urandom_range(0, 9) < 3), 4'($urandom_range(0, 15)), wd);
    end
    cyc('0, 1'b0, 4'd0, 32'h0);
    summary();
  end
endmodule